// File: doc/BRIEF.md
# Packetizing Transmit Network Interface

This block sits on the sending side of a tile that talks to other tiles over a packet-switched serial fabric. It watches a set of single-bit outgoing nets. Each net has a destination tile address and a destination port id, and both are written into a small configuration table before traffic starts. Whenever a net's value differs from the value last sent for it, the net is marked as pending. A programmable refresh timer can also mark every enabled net as pending at a fixed interval.

Pending nets that share a destination address are packed together into one fixed 40-bit packet. The packet holds the address and up to seven slots. Each slot carries a port id and one data bit. Finished packets wait in a small FIFO until the transceiver side accepts them through a valid/ready handshake. When the FIFO is full, packet generation stops, but the nets keep being sampled. The value that finally goes out is therefore always the latest one.

Top module: `txni_packetizer`

## Requirements
- R1: A packet is 40 bits. Bits [39:28] hold the destination address as four 3-bit layer fields, with the top layer in [39:37] and the bottom layer in [30:28]. Slot k (k = 0..6) occupies bits [27-4k : 24-4k], with the port id in the upper three bits and the data bit in the lowest bit.
- R2: Writing with `cfg_we_i` high stores the address, port and enable for net `cfg_idx_i`. A net whose enable is low, or whose port is 3'b111, never appears in any packet, and its changes produce no packet.
- R3: When an enabled net's sampled value differs from the value last sent for it, a packet addressed to that net's destination is produced, carrying the new value.
- R4: All pending nets with the same destination address go into one packet. They fill the slots in ascending net index, starting at slot 0.
- R5: If more than seven nets with the same address are pending, the seven lowest-indexed nets go into the first packet and the rest go into the next packet.
- R6: Used slots are contiguous from slot 0. Each unused slot carries port 3'b111 with data bit 0.
- R7: When pending nets have different addresses, the packet for the address of the lowest-indexed pending net is emitted first.
- R8: With `refresh_period_i` = P > 0, every P cycles all enabled nets are marked pending and re-sent with their current values. With P = 0, no refresh occurs.
- R9: While `pkt_valid_o` is high and `pkt_ready_i` is low, the valid signal and the packet data are held. Packets leave in the order they were generated. A full FIFO stalls generation without losing the latest value of any net.
- R10: After reset, `pkt_valid_o` is low, and no packet is produced while all nets stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration table write strobe |
| cfg_idx_i | input | IDX_W | Net index to configure |
| cfg_addr_i | input | 12 | Destination tile address for that net |
| cfg_port_i | input | 3 | Destination port id for that net (3'b111 is reserved) |
| cfg_en_i | input | 1 | Enable for that net |
| refresh_period_i | input | REF_W | Refresh interval in cycles (0 disables refresh) |
| nets_i | input | NUM_NETS | Outgoing inter-tile nets |
| pkt_valid_o | output | 1 | Packet available at the FIFO head |
| pkt_ready_i | input | 1 | Transceiver accepts the head packet |
| pkt_data_o | output | 40 | Head packet |

## Verification
The bench first toggles a single net. This confirms the field placement and the padding of idle slots. It then toggles two nets of the same group in the same cycle, which shows whether they merge into one packet or come out as two. A nine-net burst to one address shows whether the group is split at the seven-slot limit. Simultaneous changes on nets bound for different addresses expose the ordering by net index. Toggles on a disabled net and on a reserved-port net must produce silence, while a sibling net with a valid configuration still gets through alone. A stall with the FIFO filled and one change left pending distinguishes held output from lost or reordered packets. A quiet period with refresh enabled must reproduce every enabled group exactly once per interval.

// File: rtl/txni_pkg.sv
package txni_pkg;
  localparam int LAYER_W = 3;
  localparam int LAYERS  = 4;
  localparam int ADDR_W  = LAYER_W * LAYERS;
  localparam int PORT_W  = 3;
  localparam int SLOTS   = 7;
  localparam int SLOT_W  = PORT_W + 1;
  localparam int PKT_W   = ADDR_W + SLOTS * SLOT_W;

  localparam logic [PORT_W-1:0] PORT_NONE = '1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PORT_W-1:0] port_t;

  typedef struct packed {
    port_t port;
    logic  bit_v;
  } slot_t;

  // slot[SLOTS-1] is slot 0 (most significant after the address)
  typedef struct packed {
    addr_t                addr;
    slot_t [SLOTS-1:0]    slot;
  } pkt_t;

  function automatic slot_t idle_slot();
    slot_t s;
    s.port  = PORT_NONE;
    s.bit_v = 1'b0;
    return s;
  endfunction
endpackage

// File: rtl/txni_cfg_table.sv
module txni_cfg_table
  import txni_pkg::*;
#(
  parameter int NUM_NETS = 16,
  parameter int IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  addr_t            addr_i,
  input  port_t            port_i,
  input  logic             en_i,
  output addr_t            addr_o [NUM_NETS],
  output port_t            port_o [NUM_NETS],
  output logic [NUM_NETS-1:0] live_o
);
  for (genvar g = 0; g < NUM_NETS; g++) begin : g_ent
    addr_t addr_q;
    port_t port_q;
    logic  en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        port_q <= PORT_NONE;
        en_q   <= 1'b0;
      end else if (we_i && idx_i == IDX_W'(g)) begin
        addr_q <= addr_i;
        port_q <= port_i;
        en_q   <= en_i;
      end
    end

    assign addr_o[g] = addr_q;
    assign port_o[g] = port_q;
    assign live_o[g] = en_q && (port_q != PORT_NONE);
  end
endmodule

// File: rtl/txni_net_track.sv
module txni_net_track #(
  parameter int NUM_NETS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_NETS-1:0] nets_i,
  input  logic [NUM_NETS-1:0] live_i,
  input  logic                refresh_i,
  input  logic [NUM_NETS-1:0] take_i,
  input  logic                push_i,
  output logic [NUM_NETS-1:0] val_o,
  output logic [NUM_NETS-1:0] need_o
);
  for (genvar g = 0; g < NUM_NETS; g++) begin : g_net
    logic val_q, sent_q, refr_q;
    logic done;

    assign done = push_i && take_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q  <= 1'b0;
        sent_q <= 1'b0;
        refr_q <= 1'b0;
      end else begin
        val_q <= nets_i[g];
        if (done) sent_q <= val_q;
        // a fresh expiry wins over a same-cycle send
        if (refresh_i && live_i[g]) refr_q <= 1'b1;
        else if (done)              refr_q <= 1'b0;
      end
    end

    assign val_o[g]  = val_q;
    assign need_o[g] = live_i[g] && ((val_q ^ sent_q) || refr_q);
  end
endmodule

// File: rtl/txni_refresh_timer.sv
module txni_refresh_timer #(
  parameter int REF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REF_W-1:0] period_i,
  output logic             expire_o
);
  logic [REF_W-1:0] cnt_q;

  assign expire_o = (period_i != '0) && (cnt_q >= period_i - REF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (period_i == '0)    cnt_q <= '0;
    else if (expire_o)          cnt_q <= '0;
    else                        cnt_q <= cnt_q + REF_W'(1);
  end
endmodule

// File: rtl/txni_slot_pack.sv
module txni_slot_pack
  import txni_pkg::*;
#(
  parameter int NUM_NETS = 16
) (
  input  logic [NUM_NETS-1:0] need_i,
  input  logic [NUM_NETS-1:0] val_i,
  input  addr_t               addr_i [NUM_NETS],
  input  port_t               port_i [NUM_NETS],
  output logic                any_o,
  output pkt_t                pkt_o,
  output logic [NUM_NETS-1:0] take_o
);
  addr_t lead_addr;

  assign any_o = |need_i;

  // leader: lowest-index pending net picks the destination
  always_comb begin
    logic found;
    found     = 1'b0;
    lead_addr = '0;
    for (int i = 0; i < NUM_NETS; i++) begin
      if (need_i[i] && !found) begin
        lead_addr = addr_i[i];
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    int n;
    n          = 0;
    take_o     = '0;
    pkt_o.addr = lead_addr;
    for (int k = 0; k < SLOTS; k++) pkt_o.slot[k] = idle_slot();
    for (int i = 0; i < NUM_NETS; i++) begin
      if (need_i[i] && addr_i[i] == lead_addr && n < SLOTS) begin
        pkt_o.slot[SLOTS-1-n].port  = port_i[i];
        pkt_o.slot[SLOTS-1-n].bit_v = val_i[i];
        take_o[i] = 1'b1;
        n = n + 1;
      end
    end
  end
endmodule

// File: rtl/txni_fifo.sv
module txni_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          wr_en, rd_en;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rd_q];
  assign wr_en   = push_i && !full_o;
  assign rd_en   = valid_o && ready_i;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (rd_en) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_en);
    end
  end
endmodule

// File: rtl/txni_packetizer.sv
module txni_packetizer
  import txni_pkg::*;
#(
  parameter int NUM_NETS   = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int REF_W      = 16,
  parameter int IDX_W      = (NUM_NETS > 1) ? $clog2(NUM_NETS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [PORT_W-1:0]   cfg_port_i,
  input  logic                cfg_en_i,
  input  logic [REF_W-1:0]    refresh_period_i,
  input  logic [NUM_NETS-1:0] nets_i,
  output logic                pkt_valid_o,
  input  logic                pkt_ready_i,
  output logic [PKT_W-1:0]    pkt_data_o
);
  addr_t               net_addr [NUM_NETS];
  port_t               net_port [NUM_NETS];
  logic [NUM_NETS-1:0] live, val, need, take;
  logic                refresh, any, full, push;
  pkt_t                pkt;

  txni_cfg_table #(.NUM_NETS(NUM_NETS), .IDX_W(IDX_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .addr_i(cfg_addr_i),
    .port_i(cfg_port_i), .en_i(cfg_en_i),
    .addr_o(net_addr), .port_o(net_port), .live_o(live)
  );

  txni_refresh_timer #(.REF_W(REF_W)) u_tmr (
    .clk_i, .rst_ni, .period_i(refresh_period_i), .expire_o(refresh)
  );

  txni_net_track #(.NUM_NETS(NUM_NETS)) u_trk (
    .clk_i, .rst_ni, .nets_i, .live_i(live), .refresh_i(refresh),
    .take_i(take), .push_i(push), .val_o(val), .need_o(need)
  );

  txni_slot_pack #(.NUM_NETS(NUM_NETS)) u_pack (
    .need_i(need), .val_i(val), .addr_i(net_addr), .port_i(net_port),
    .any_o(any), .pkt_o(pkt), .take_o(take)
  );

  assign push = any && !full;

  txni_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .data_i(pkt), .full_o(full),
    .valid_o(pkt_valid_o), .ready_i(pkt_ready_i), .data_o(pkt_data_o)
  );
endmodule

// File: rtl/txni_packetizer_chk.sv
module txni_packetizer_chk
  import txni_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_valid_o,
  input logic             pkt_ready_i,
  input logic [PKT_W-1:0] pkt_data_o
);
  function automatic logic contiguous(logic [PKT_W-1:0] d);
    pkt_t p;
    logic idle, ok;
    p = d; idle = 1'b0; ok = 1'b1;
    for (int k = 0; k < SLOTS; k++) begin
      if (p.slot[SLOTS-1-k].port == PORT_NONE) idle = 1'b1;
      else if (idle) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic idle_zero(logic [PKT_W-1:0] d);
    pkt_t p;
    logic ok;
    p = d; ok = 1'b1;
    for (int k = 0; k < SLOTS; k++)
      if (p.slot[k].port == PORT_NONE && p.slot[k].bit_v) ok = 1'b0;
    return ok;
  endfunction

  p_hold_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o);

  p_hold_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i |=> $stable(pkt_data_o));

  p_slot0_used_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> pkt_data_o[PKT_W-ADDR_W-1 -: PORT_W] != PORT_NONE);

  p_contiguous_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> contiguous(pkt_data_o));

  p_idle_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> idle_zero(pkt_data_o));
endmodule

bind txni_packetizer txni_packetizer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pkt_valid_o(pkt_valid_o),
  .pkt_ready_i(pkt_ready_i), .pkt_data_o(pkt_data_o)
);

// File: tb/txni_packetizer_test.sv
module txni_packetizer_test;
  localparam int N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_idx_i = '0;
  logic [11:0] cfg_addr_i = '0;
  logic [2:0]  cfg_port_i = '0;
  logic        cfg_en_i = 1'b0;
  logic [15:0] refresh_period_i = '0;
  logic [N-1:0] nets_i = '0;
  logic        pkt_valid_o;
  logic        pkt_ready_i = 1'b1;
  logic [39:0] pkt_data_o;

  int checks = 0;
  int errors = 0;

  logic [11:0]  b_addr [N];
  logic [2:0]   b_port [N];
  logic [N-1:0] nv = '0;

  localparam logic [11:0] ADR_A = {3'd1, 3'd2, 3'd3, 3'd4};
  localparam logic [11:0] ADR_B = {3'd5, 3'd0, 3'd0, 3'd1};
  localparam logic [11:0] ADR_C = {3'd7, 3'd6, 3'd0, 3'd2};

  txni_packetizer uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input logic ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected packet from R1 layout: idle slot = port 7, data 0 (R6)
  function automatic logic [39:0] mk(input logic [11:0] a, input logic [N-1:0] m);
    logic [39:0] r;
    int n;
    r = '0; n = 0;
    r[39:28] = a;
    for (int k = 0; k < 7; k++) r[27-4*k -: 4] = 4'b1110;
    for (int i = 0; i < N; i++)
      if (m[i]) begin
        r[27-4*n -: 4] = {b_port[i], nv[i]};
        n++;
      end
    return r;
  endfunction

  task automatic cfg(input int i, input logic [11:0] a, input logic [2:0] p, input logic e);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 4'(i); cfg_addr_i = a; cfg_port_i = p; cfg_en_i = e;
    b_addr[i] = a; b_port[i] = p;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic drive();
    @(negedge clk_i);
    nets_i = nv;
  endtask

  task automatic get_pkt(output logic [39:0] d, output logic got);
    got = 1'b0; d = '0;
    for (int t = 0; t < 60 && !got; t++) begin
      @(negedge clk_i);
      if (pkt_valid_o) begin d = pkt_data_o; got = 1'b1; end
    end
  endtask

  task automatic expect_pkt(input logic [39:0] exp, input string req);
    logic [39:0] d;
    logic got;
    get_pkt(d, got);
    chk(got && d == exp, req, d, exp);
  endtask

  task automatic expect_none(input int cyc, input string req);
    logic seen;
    logic [39:0] d;
    seen = 1'b0; d = '0;
    for (int t = 0; t < cyc; t++) begin
      @(negedge clk_i);
      if (pkt_valid_o && !seen) begin seen = 1'b1; d = pkt_data_o; end
    end
    chk(!seen, req, d, 40'h0);
  endtask

  task automatic t_reset();
    chk(pkt_valid_o == 1'b0, "R10 valid low after reset", 40'(pkt_valid_o), 40'h0);
    expect_none(10, "R10 idle after reset");
  endtask

  task automatic t_config();
    for (int i = 0; i < 9; i++) cfg(i, ADR_A, 3'(i % 7), 1'b1);
    cfg(9,  ADR_B, 3'd0, 1'b1);
    cfg(10, ADR_B, 3'd1, 1'b1);
    cfg(11, ADR_B, 3'd2, 1'b1);
    cfg(12, ADR_C, 3'd4, 1'b0);
    cfg(13, ADR_C, 3'd7, 1'b1);
    cfg(14, ADR_C, 3'd5, 1'b1);
    cfg(15, ADR_C, 3'd6, 1'b1);
    expect_none(8, "R2 configuration alone sends nothing");
  endtask

  task automatic t_single();
    logic [39:0] d, e;
    logic got;
    nv[9] = 1'b1; drive();
    e = mk(ADR_B, 16'h0200);
    get_pkt(d, got);
    chk(got && d == e, "R3 single change", d, e);
    chk(d[39:37] == 3'd5 && d[30:28] == 3'd1, "R1 layer fields", d, e);
    chk(d[27:24] == 4'b0001, "R1 slot0 port/data", d, e);
    chk(d[23:0] == {6{4'b1110}}, "R6 idle slots", d, e);
  endtask

  task automatic t_group();
    nv[10] = 1'b1; nv[11] = 1'b1; drive();
    expect_pkt(mk(ADR_B, 16'h0C00), "R4 grouped packet");
    expect_none(6, "R4 no second packet");
  endtask

  task automatic t_split();
    nv[8:0] = '1; drive();
    expect_pkt(mk(ADR_A, 16'h007F), "R5 first seven");
    expect_pkt(mk(ADR_A, 16'h0180), "R5 remainder");
  endtask

  task automatic t_order();
    nv[14] = 1'b1; nv[9] = 1'b0; drive();
    expect_pkt(mk(ADR_B, 16'h0200), "R7 lowest index first");
    expect_pkt(mk(ADR_C, 16'h4000), "R7 second address");
  endtask

  task automatic t_ignored();
    nv[12] = 1'b1; nv[13] = 1'b1; drive();
    expect_none(10, "R2 disabled and reserved-port nets silent");
    nv[15] = 1'b1; drive();
    expect_pkt(mk(ADR_C, 16'h8000), "R2 sibling alone in packet");
  endtask

  task automatic t_stall();
    logic [39:0] exp [5];
    logic [39:0] d0, d;
    logic got;
    @(negedge clk_i); pkt_ready_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      nv[9] = ~nv[9]; drive();
      exp[k] = mk(ADR_B, 16'h0200);
      repeat (5) @(negedge clk_i);
    end
    d0 = pkt_data_o;
    repeat (3) @(negedge clk_i);
    chk(pkt_valid_o && pkt_data_o == d0, "R9 head held while stalled", pkt_data_o, d0);
    pkt_ready_i = 1'b1;
    chk(pkt_valid_o && pkt_data_o == exp[0], "R9 stalled packet 0", pkt_data_o, exp[0]);
    for (int k = 1; k < 5; k++) begin
      get_pkt(d, got);
      chk(got && d == exp[k], $sformatf("R9 stalled packet %0d", k), d, exp[k]);
    end
    expect_none(6, "R9 nothing extra after drain");
  endtask

  task automatic t_refresh();
    @(negedge clk_i); refresh_period_i = 16'd16;
    expect_pkt(mk(ADR_A, 16'h007F), "R8 refresh group A first");
    refresh_period_i = 16'd0;
    expect_pkt(mk(ADR_A, 16'h0180), "R8 refresh group A rest");
    expect_pkt(mk(ADR_B, 16'h0E00), "R8 refresh group B");
    expect_pkt(mk(ADR_C, 16'hC000), "R8 refresh group C");
    expect_none(40, "R8 period zero stops refresh");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_config();
    t_single();
    t_group();
    t_split();
    t_order();
    t_ignored();
    t_stall();
    t_refresh();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule